// File: doc/BRIEF.md
# Cycle and duty PWM channel

This block is one pulse-width-modulation channel. A free-running up-counter advances on a one-cycle count-enable pulse that an external prescaler supplies. Two programmed limits shape the waveform. When the counter equals the cycle limit, it returns to zero and the output level goes high. When the counter equals the duty limit, the output level goes low. A run bit gates counting.

Stopping the channel only freezes it. The counter, both limits and the output level all stay as they are, so a restart continues from the frozen count. A start from a counter of zero spends its first count pulse without incrementing, which makes the first period exactly one count pulse longer than programmed. The mode settings are the output polarity and the choice of count-enable source. Software may write them at any time, but the channel adopts them only on the cycle in which counting starts.

Top module: `pwm_cycle_duty`

## Requirements
- R1: After reset the counter reads 0 and `pwm_out` is low.
- R2: The counter changes only on a clock edge where `run` is 1 and the selected count enable is 1, or where software writes the counter. With no pulse on the selected enable, the counter holds.
- R3: A count pulse that finds the counter equal to the cycle limit C loads 0 into the counter and drives the level high. A counter running freely therefore has a period of C+1 count pulses.
- R4: A count pulse that finds the counter equal to the duty limit D, where D < C, drives the level low. The level is high for D+1 of every C+1 count pulses.
- R5: When D >= C, the level stays high for the whole period (the cycle match takes priority when D = C).
- R6: While `run` is 0, `count_out` and `pwm_out` hold their values whatever the count enables do. When `run` returns to 1 with a nonzero counter, the first count pulse increments from the frozen value.
- R7: On the cycle in which `run` rises, a counter value of 0 arms a hold. The first count pulse after that is consumed without incrementing. A start from a nonzero value arms no hold.
- R8: The mode value is bit 0 = invert output and bit 1 = count from `tick_b` instead of `tick_a`. It takes effect only on the cycle in which `run` rises. A write while running or halted changes neither the pin nor the counting until the next start.
- R9: A write with `reg_we` = 1 goes to the register that `reg_sel` selects: 0 = counter, 1 = cycle limit, 2 = duty limit, 3 = mode. A counter write overrides an increment in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_sel | input | 2 | Register select (0 counter, 1 cycle, 2 duty, 3 mode) |
| reg_wdata | input | W | Write data |
| tick_a | input | 1 | Count enable source A (one-cycle pulse) |
| tick_b | input | 1 | Count enable source B (one-cycle pulse) |
| run | input | 1 | Start bit; 1 counts, 0 halts |
| pwm_out | output | 1 | PWM output pin |
| count_out | output | W | Current counter value |

## Verification
Several properties are checked on every clock. The counter and pin stay frozen while halted, and the counter stays still when no pulse arrives on the selected enable. A cycle match must reset the counter and set the level, and a plain count step must increment by one. The level stays high when the duty limit is at or above the cycle limit. Some behaviour shows only in the bench's scenarios: the exact high and low proportions over whole periods for several limit pairs, the extra pulse consumed on a start from zero, and the polarity and source changes that wait for the next start.

// File: rtl/pwm_cycle_duty.sv
module pwm_cycle_duty #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         reg_we,
  input  logic [1:0]   reg_sel,
  input  logic [W-1:0] reg_wdata,
  input  logic         tick_a,
  input  logic         tick_b,
  input  logic         run,
  output logic         pwm_out,
  output logic [W-1:0] count_out
);

  logic [W-1:0] cnt, cyc_r, duty_r;
  logic [1:0]   mode_new, mode_act;
  logic         level, run_q, hold;

  wire start_edge = run & ~run_q;
  wire [1:0] mode_now = start_edge ? mode_new : mode_act;
  wire tick_sel = mode_now[1] ? tick_b : tick_a;
  wire cnt_wr = reg_we && (reg_sel == 2'd0);
  wire armed = hold | (start_edge && (cnt == '0));
  wire step = run & tick_sel;
  wire adv = step & ~armed;
  wire cyc_hit = (cnt == cyc_r);
  wire duty_hit = (cnt == duty_r);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt      <= '0;
      cyc_r    <= '0;
      duty_r   <= '0;
      mode_new <= '0;
      mode_act <= '0;
      level    <= 1'b0;
      run_q    <= 1'b0;
      hold     <= 1'b0;
    end else begin
      run_q <= run;
      if (start_edge) mode_act <= mode_new;

      if (reg_we && reg_sel == 2'd1) cyc_r    <= reg_wdata;
      if (reg_we && reg_sel == 2'd2) duty_r   <= reg_wdata;
      if (reg_we && reg_sel == 2'd3) mode_new <= reg_wdata[1:0];

      if (cnt_wr)      cnt <= reg_wdata;
      else if (adv)    cnt <= cyc_hit ? '0 : cnt + W'(1);

      if (adv) begin
        if (cyc_hit)       level <= 1'b1;
        else if (duty_hit) level <= 1'b0;
      end

      if (step && armed)                    hold <= 1'b0;
      else if (start_edge && (cnt == '0))   hold <= 1'b1;
    end
  end

  assign pwm_out   = level ^ mode_act[0];
  assign count_out = cnt;

  assert_halt_count_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !cnt_wr) |=> count_out == $past(count_out));

  assert_halt_pin_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> $stable(pwm_out));

  assert_no_tick_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick_sel && !cnt_wr) |=> $stable(count_out));

  assert_cycle_match_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (run && tick_sel && !armed && cyc_hit && !cnt_wr) |=> (count_out == '0) && level);

  assert_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (run && tick_sel && !armed && !cyc_hit && !cnt_wr) |=> count_out == $past(count_out) + W'(1));

  assert_zero_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (start_edge && tick_sel && (count_out == '0) && !cnt_wr) |=> count_out == '0);

  assert_full_high_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (level && (duty_r >= cyc_r) && (cnt <= cyc_r)) |=> level);

  assert_mode_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !start_edge |=> $stable(mode_act));

endmodule

// File: tb/pwm_cycle_duty_test.sv
module pwm_cycle_duty_test;
  localparam int W = 16;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         reg_we = 1'b0;
  logic [1:0]   reg_sel = '0;
  logic [W-1:0] reg_wdata = '0;
  logic         tick_a = 1'b0;
  logic         tick_b = 1'b0;
  logic         run = 1'b0;
  logic         pwm_out;
  logic [W-1:0] count_out;

  int n_checks = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  pwm_cycle_duty #(.W(W)) uut (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_sel(reg_sel),
    .reg_wdata(reg_wdata), .tick_a(tick_a), .tick_b(tick_b), .run(run),
    .pwm_out(pwm_out), .count_out(count_out)
  );

  // cycle, duty, invert, high pulses per period
  localparam int VEC [10][4] = '{
    '{9, 3, 0, 4},  '{9, 0, 0, 1},  '{9, 8, 0, 9},  '{9, 9, 0, 10},
    '{9, 20, 0, 10}, '{4, 2, 1, 3}, '{15, 7, 0, 8}, '{1, 0, 0, 1},
    '{0, 0, 0, 1},  '{6, 1, 1, 2}
  };

  task automatic check(input string req, input int act, input int exp, input string what);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] sel, input int data);
    reg_we = 1'b1; reg_sel = sel; reg_wdata = W'(data);
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  endtask

  initial begin
    repeat (200000) @(negedge clk);
    if (!done) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog: actual running expected finished");
      finish_run();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1", count_out, 0, "counter after reset");
    check("R1", pwm_out, 0, "pin after reset");
    rst_n = 1'b1;
    tick_a = 1'b1;
    @(negedge clk);

    // R3 R4 R5 R8: proportions over whole periods
    for (int v = 0; v < 10; v++) begin
      int c, d, inv, hi, per, cnt_hi, exp_hi;
      c = VEC[v][0]; d = VEC[v][1]; inv = VEC[v][2]; hi = VEC[v][3];
      per = c + 1;
      run = 1'b0;
      @(negedge clk);
      wr(2'd0, 0); wr(2'd1, c); wr(2'd2, d); wr(2'd3, inv);
      run = 1'b1;
      repeat (2 * per + 3) @(negedge clk);
      cnt_hi = 0;
      for (int k = 0; k < 4 * per; k++) begin
        if (pwm_out) cnt_hi++;
        @(negedge clk);
      end
      exp_hi = inv != 0 ? 4 * (per - hi) : 4 * hi;
      check(d >= c ? "R5" : "R4", cnt_hi, exp_hi, $sformatf("high count c=%0d d=%0d", c, d));
    end

    // R3 R7: start from zero, twelve edges with C=9 D=3
    run = 1'b0;
    @(negedge clk);
    wr(2'd0, 0); wr(2'd1, 9); wr(2'd2, 3); wr(2'd3, 0);
    run = 1'b1;
    @(negedge clk);
    check("R7", count_out, 0, "first pulse consumed from zero");
    @(negedge clk);
    check("R7", count_out, 1, "second pulse increments");
    repeat (10) @(negedge clk);
    check("R3", count_out, 1, "counter after cycle wrap");
    check("R3", pwm_out, 1, "pin set by cycle match");

    // R6: halt freezes
    run = 1'b0;
    repeat (20) @(negedge clk);
    check("R6", count_out, 1, "counter frozen while halted");
    check("R6", pwm_out, 1, "pin held while halted");
    run = 1'b1;
    @(negedge clk);
    check("R6", count_out, 2, "restart continues without extra pulse");

    // R8: mode written while halted waits for start
    run = 1'b0;
    @(negedge clk);
    wr(2'd3, 1);
    wr(2'd0, 5);
    @(negedge clk);
    check("R8", pwm_out, 1, "polarity write ignored while halted");
    run = 1'b1;
    @(negedge clk);
    check("R7", count_out, 6, "nonzero start arms no hold");
    check("R8", pwm_out, 0, "polarity adopted at start");
    wr(2'd3, 0);
    @(negedge clk);
    check("R8", pwm_out, 0, "polarity write ignored while running");
    check("R2", count_out, 8, "counter while running");

    // R2 R8: count source select
    run = 1'b0;
    @(negedge clk);
    wr(2'd3, 2);
    wr(2'd0, 4);
    run = 1'b1;
    repeat (5) @(negedge clk);
    check("R2", count_out, 4, "no pulse on selected source");
    tick_b = 1'b1;
    @(negedge clk);
    tick_b = 1'b0;
    @(negedge clk);
    check("R2", count_out, 5, "single pulse on selected source");

    // R9: counter write beats increment
    tick_b = 1'b1;
    wr(2'd0, 7);
    tick_b = 1'b0;
    check("R9", count_out, 7, "counter write overrides increment");
    wr(2'd1, 3);
    tick_b = 1'b1;
    @(negedge clk);
    tick_b = 1'b0;
    check("R9", count_out, 8, "cycle write does not touch counter");

    done = 1'b1;
    finish_run();
  end
endmodule